// File: doc/BRIEF.md
# Segment-Aware Scratchpad Data Memory

This block serves the data port of a 32-bit CPU. Each request carries a virtual address, a read or write kind, a size (byte, halfword or word) and write data. The block strips the segment bits to form a physical address. It then decides whether the access belongs to a 1 KiB on-chip scratchpad RAM or must go out on an external bus.

Only the user segment and the cached kernel segment may reach the scratchpad. The uncached kernel segment and the upper kernel segments are always forwarded to the bus, even when their physical address falls inside the scratchpad window.

Scratchpad accesses finish in one cycle and never touch the bus. Bus accesses use a valid/ready handshake, and the CPU sees a done strobe one cycle after the handshake. Sub-word data is byte-addressed, stored little-endian and zero-extended on reads. Unaligned halfword and word requests are refused and flagged.

Top module: `spad_dmem`

## Requirements
- R1: The physical address is the virtual address ANDed with 0x1FFFFFFF. A request hits the scratchpad when two conditions both hold. First, the physical address ANDed with 0xFFFFFC00 equals 0x1F800000. Second, virtual bits [31:29] are 0xx (user) or 100 (cached kernel). The RAM byte offset is physical bits [9:0].
- R2: A request whose virtual bits [31:29] are 101 (uncached) or 11x never hits the scratchpad. It is forwarded to the bus with `ext_addr` equal to the physical address, and the scratchpad contents stay unchanged.
- R3: Storage is little-endian. In a word at offset o, bits [7:0] live at byte o and bits [31:24] live at byte o+3. Size encoding is 00 byte, 01 halfword, 10 word; 11 behaves as word.
- R4: A byte write stores only `cpu_wdata[7:0]` at its offset. A halfword write stores only `cpu_wdata[15:0]` at offsets o and o+1. All other bytes are left unchanged.
- R5: Byte and halfword reads, whether from the scratchpad or the bus, return their data zero-extended to 32 bits.
- R6: A scratchpad hit raises `cpu_done` exactly one cycle after the request. A read hit presents its data on `cpu_rdata` in that same cycle. No bus transaction is started.
- R7: A halfword with address bit 0 set, or a word with address bits [1:0] nonzero, is misaligned. One cycle after such a request, `cpu_done` and `cpu_misalign` both rise. Nothing is written, no bus transaction starts, and `cpu_rdata` is zero.
- R8: `ext_valid` and the bus request fields stay stable until `ext_ready` is seen. `cpu_done` rises one cycle after the handshake, and `ext_valid` drops at that same edge.
- R9: A `cpu_req` raised while a bus access is outstanding is ignored. It neither writes the scratchpad nor starts a second bus access.
- R10: During and after reset, `cpu_done`, `cpu_misalign` and `ext_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request strobe, sampled when idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| cpu_addr | input | 32 | Virtual byte address |
| cpu_wdata | input | 32 | Write data, right-justified |
| cpu_done | output | 1 | Completion strobe |
| cpu_misalign | output | 1 | Request refused as unaligned (with cpu_done) |
| cpu_rdata | output | 32 | Zero-extended read data while cpu_done of a read |
| ext_valid | output | 1 | Bus request valid |
| ext_we | output | 1 | Bus write |
| ext_size | output | 2 | Bus access size |
| ext_addr | output | 32 | Bus physical address |
| ext_wdata | output | 32 | Bus write data |
| ext_ready | input | 1 | Bus completes the request |
| ext_rdata | input | 32 | Bus read data, right-justified |

## Verification
The assertions check several properties on every cycle. They check that uncached addresses never decode as hits and that a hit completes in one cycle without raising `ext_valid`. They check that a misaligned request completes flagged and with no bus activity. They check that bus requests hold steady until ready and that no RAM write happens while a bus access is outstanding. They also check that byte hit reads carry zero upper bits.

Stored contents can only be shown by the bench scenarios, which sweep every offset and size against a byte-array model. The same applies to little-endian lane placement, partial-write masking, segment aliasing of one physical window, and the bus data returned for each size.

// File: rtl/spad_pkg.sv
package spad_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUS  = 1'b1
    } ctl_state_e;

    typedef struct packed {
        ctl_state_e  state;
        logic        done;
        logic        misal;
        logic        rd;
        logic        from_spad;
        logic [1:0]  sz;
        logic [1:0]  off;
        logic        ext_valid;
        logic        ext_we;
        logic [1:0]  ext_size;
        logic [31:0] ext_addr;
        logic [31:0] ext_wdata;
        logic [31:0] bus_data;
    } ctl_t;

    // Byte enables for a 4-lane word, little-endian lane order.
    function automatic logic [3:0] lane_enable(input logic [1:0] sz, input logic [1:0] off);
        case (sz)
            2'b00:   return 4'b0001 << off;
            2'b01:   return off[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    // Replicate the low bytes so every enabled lane sees the right data.
    function automatic logic [31:0] lane_data(input logic [1:0] sz, input logic [31:0] w);
        case (sz)
            2'b00:   return {4{w[7:0]}};
            2'b01:   return {2{w[15:0]}};
            default: return w;
        endcase
    endfunction

    function automatic logic [31:0] size_mask(input logic [1:0] sz, input logic [31:0] d);
        case (sz)
            2'b00:   return {24'b0, d[7:0]};
            2'b01:   return {16'b0, d[15:0]};
            default: return d;
        endcase
    endfunction

    function automatic logic [31:0] lane_extract(input logic [1:0] sz, input logic [1:0] off,
                                                 input logic [31:0] word);
        return size_mask(sz, word >> {off, 3'b000});
    endfunction

endpackage

// File: rtl/spad_decode.sv
module spad_decode #(
    parameter logic [31:0] SPAD_BASE  = 32'h1F80_0000,
    parameter int          SPAD_BYTES = 1024,
    parameter logic [31:0] PHYS_MASK  = 32'h1FFF_FFFF,
    parameter int          OFF_W      = $clog2(SPAD_BYTES)
) (
    input  logic [31:0]      va,
    input  logic [1:0]       size,
    output logic [31:0]      phys,
    output logic [OFF_W-1:0] offset,
    output logic             hit,
    output logic             misal
);
    localparam logic [31:0] WIN_MASK = ~(32'(SPAD_BYTES) - 32'd1);

    logic seg_ok;

    always_comb begin
        phys   = va & PHYS_MASK;
        offset = phys[OFF_W-1:0];
        // user (0xx) or cached kernel (100) may see the scratchpad
        seg_ok = (va[31] == 1'b0) || (va[31:29] == 3'b100);
        hit    = seg_ok && ((phys & WIN_MASK) == SPAD_BASE);
        case (size)
            2'b00:   misal = 1'b0;
            2'b01:   misal = va[0];
            default: misal = |va[1:0];
        endcase
    end
endmodule

// File: rtl/spad_ram.sv
module spad_ram #(
    parameter int WORDS = 256,
    parameter int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             en,
    input  logic             we,
    input  logic [3:0]       be,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata
);
    for (genvar g = 0; g < 4; g++) begin : g_lane
        logic [7:0] mem [WORDS];
        logic [7:0] rq;

        always_ff @(posedge clk) begin
            if (en) begin
                if (we) begin
                    if (be[g]) mem[idx] <= wdata[8*g +: 8];
                end else begin
                    rq <= mem[idx];
                end
            end
        end

        assign rdata[8*g +: 8] = rq;
    end
endmodule

// File: rtl/spad_dmem.sv
module spad_dmem
    import spad_pkg::*;
#(
    parameter logic [31:0] SPAD_BASE  = 32'h1F80_0000,
    parameter int          SPAD_BYTES = 1024,
    parameter logic [31:0] PHYS_MASK  = 32'h1FFF_FFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [1:0]  cpu_size,
    input  logic [31:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    output logic        cpu_done,
    output logic        cpu_misalign,
    output logic [31:0] cpu_rdata,
    output logic        ext_valid,
    output logic        ext_we,
    output logic [1:0]  ext_size,
    output logic [31:0] ext_addr,
    output logic [31:0] ext_wdata,
    input  logic        ext_ready,
    input  logic [31:0] ext_rdata
);
    localparam int OFF_W = $clog2(SPAD_BYTES);
    localparam int WORDS = SPAD_BYTES / 4;
    localparam int IDX_W = OFF_W - 2;

    logic [31:0]      dec_phys;
    logic [OFF_W-1:0] dec_off;
    logic             dec_hit;
    logic             dec_mis;

    logic             ram_en;
    logic             ram_we;
    logic [31:0]      ram_rdata;
    logic             ctl_idle;

    ctl_t c_d, c_q;

    spad_decode #(
        .SPAD_BASE (SPAD_BASE),
        .SPAD_BYTES(SPAD_BYTES),
        .PHYS_MASK (PHYS_MASK),
        .OFF_W     (OFF_W)
    ) decode_i (
        .va    (cpu_addr),
        .size  (cpu_size),
        .phys  (dec_phys),
        .offset(dec_off),
        .hit   (dec_hit),
        .misal (dec_mis)
    );

    spad_ram #(
        .WORDS(WORDS),
        .IDX_W(IDX_W)
    ) ram_i (
        .clk  (clk),
        .en   (ram_en),
        .we   (ram_we),
        .be   (lane_enable(cpu_size, dec_off[1:0])),
        .idx  (dec_off[OFF_W-1:2]),
        .wdata(lane_data(cpu_size, cpu_wdata)),
        .rdata(ram_rdata)
    );

    assign ctl_idle = (c_q.state == ST_IDLE);

    always_comb begin
        c_d       = c_q;
        c_d.done  = 1'b0;
        c_d.misal = 1'b0;
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        case (c_q.state)
            ST_IDLE: begin
                if (cpu_req) begin
                    c_d.sz  = cpu_size;
                    c_d.off = dec_off[1:0];
                    if (dec_mis) begin
                        c_d.done  = 1'b1;
                        c_d.misal = 1'b1;
                        c_d.rd    = 1'b0;
                    end else if (dec_hit) begin
                        ram_en        = 1'b1;
                        ram_we        = cpu_we;
                        c_d.done      = 1'b1;
                        c_d.rd        = !cpu_we;
                        c_d.from_spad = 1'b1;
                    end else begin
                        c_d.state     = ST_BUS;
                        c_d.ext_valid = 1'b1;
                        c_d.ext_we    = cpu_we;
                        c_d.ext_size  = cpu_size;
                        c_d.ext_addr  = dec_phys;
                        c_d.ext_wdata = cpu_wdata;
                        c_d.rd        = !cpu_we;
                        c_d.from_spad = 1'b0;
                    end
                end
            end
            ST_BUS: begin
                if (ext_ready) begin
                    c_d.state     = ST_IDLE;
                    c_d.ext_valid = 1'b0;
                    c_d.done      = 1'b1;
                    c_d.bus_data  = size_mask(c_q.sz, ext_rdata);
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_comb begin
        cpu_done     = c_q.done;
        cpu_misalign = c_q.misal;
        ext_valid    = c_q.ext_valid;
        ext_we       = c_q.ext_we;
        ext_size     = c_q.ext_size;
        ext_addr     = c_q.ext_addr;
        ext_wdata    = c_q.ext_wdata;
        if (c_q.done && c_q.rd)
            cpu_rdata = c_q.from_spad ? lane_extract(c_q.sz, c_q.off, ram_rdata) : c_q.bus_data;
        else
            cpu_rdata = '0;
    end
endmodule

// File: rtl/spad_dmem_chk.sv
module spad_dmem_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_req,
    input logic        cpu_we,
    input logic [1:0]  cpu_size,
    input logic [31:0] cpu_addr,
    input logic        cpu_done,
    input logic        cpu_misalign,
    input logic [31:0] cpu_rdata,
    input logic        ext_valid,
    input logic        ext_ready,
    input logic [31:0] ext_addr,
    input logic [1:0]  ext_size,
    input logic        ext_we,
    input logic [31:0] ext_wdata,
    input logic        ctl_idle,
    input logic        dec_hit,
    input logic        dec_mis,
    input logic        ram_we
);
    logic hit_req;
    assign hit_req = ctl_idle && cpu_req && dec_hit && !dec_mis;

    // R2: uncached segment never decodes as a scratchpad hit
    a_r2_uncached_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[31:29] == 3'b101) |-> !dec_hit);

    // R6: hit completes next cycle with no bus request
    a_r6_hit_done: assert property (@(posedge clk) disable iff (!rst_n)
        hit_req |=> (cpu_done && !cpu_misalign && !ext_valid));

    // R5: byte read hits carry zero upper bits
    a_r5_byte_zext: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_req && !cpu_we && cpu_size == 2'b00) |=> (cpu_rdata[31:8] == 24'b0));

    // R7: misaligned request completes flagged, no bus
    a_r7_misalign_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_idle && cpu_req && dec_mis) |=> (cpu_done && cpu_misalign && !ext_valid));

    // R7: misalign only appears together with done
    a_r7_misalign_has_done: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_misalign |-> cpu_done);

    // R8: bus request holds steady until ready
    a_r8_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_valid && !ext_ready) |=> (ext_valid && $stable(ext_addr) && $stable(ext_size)
                                      && $stable(ext_we) && $stable(ext_wdata)));

    // R8: handshake gives done next cycle and drops valid
    a_r8_handshake_done: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_valid && ext_ready) |=> (cpu_done && !ext_valid));

    // R9: no RAM write while a bus access is outstanding
    a_r9_busy_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_idle |-> !ram_we);
endmodule

bind spad_dmem spad_dmem_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_req     (cpu_req),
    .cpu_we      (cpu_we),
    .cpu_size    (cpu_size),
    .cpu_addr    (cpu_addr),
    .cpu_done    (cpu_done),
    .cpu_misalign(cpu_misalign),
    .cpu_rdata   (cpu_rdata),
    .ext_valid   (ext_valid),
    .ext_ready   (ext_ready),
    .ext_addr    (ext_addr),
    .ext_size    (ext_size),
    .ext_we      (ext_we),
    .ext_wdata   (ext_wdata),
    .ctl_idle    (ctl_idle),
    .dec_hit     (dec_hit),
    .dec_mis     (dec_mis),
    .ram_we      (ram_we)
);

// File: tb/spad_dmem_tb_top.sv
module spad_dmem_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [1:0]  cpu_size = 2'b00;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_done;
    logic        cpu_misalign;
    logic [31:0] cpu_rdata;
    logic        ext_valid;
    logic        ext_we;
    logic [1:0]  ext_size;
    logic [31:0] ext_addr;
    logic [31:0] ext_wdata;
    logic        ext_ready = 1'b0;
    logic [31:0] ext_rdata = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int bus_lat = 0;
    int wait_cnt = 0;
    int bus_cnt = 0;
    logic [31:0] last_addr = '0;
    logic        last_we = 1'b0;
    logic [31:0] last_wdata = '0;

    logic [7:0] mdl [1024];

    always #10 clk = ~clk;

    spad_dmem dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done), .cpu_misalign(cpu_misalign), .cpu_rdata(cpu_rdata),
        .ext_valid(ext_valid), .ext_we(ext_we), .ext_size(ext_size),
        .ext_addr(ext_addr), .ext_wdata(ext_wdata),
        .ext_ready(ext_ready), .ext_rdata(ext_rdata)
    );

    function automatic logic [31:0] bus_word(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, ~a[15:0]};
    endfunction

    function automatic logic [31:0] pat(input int i);
        return 32'h9E37_79B9 * 32'(i) + 32'h1234_5678;
    endfunction

    function automatic logic [31:0] zmask(input logic [1:0] sz, input logic [31:0] d);
        if (sz == 2'b00) return {24'b0, d[7:0]};
        if (sz == 2'b01) return {16'b0, d[15:0]};
        return d;
    endfunction

    // simple bus responder, acts on falling edges only
    always @(negedge clk) begin
        if (ext_ready) begin
            ext_ready = 1'b0;
            wait_cnt  = 0;
        end else if (ext_valid) begin
            if (wait_cnt >= bus_lat) begin
                ext_ready  = 1'b1;
                ext_rdata  = bus_word(ext_addr);
                bus_cnt++;
                last_addr  = ext_addr;
                last_we    = ext_we;
                last_wdata = ext_wdata;
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mdl_rd(input logic [1:0] sz, input int o);
        logic [31:0] w;
        w = {mdl[(o+3)%1024], mdl[(o+2)%1024], mdl[(o+1)%1024], mdl[o]};
        return zmask(sz, w);
    endfunction

    task automatic mdl_wr(input logic [1:0] sz, input int o, input logic [31:0] d);
        mdl[o] = d[7:0];
        if (sz != 2'b00) mdl[o+1] = d[15:8];
        if (sz[1]) begin
            mdl[o+2] = d[23:16];
            mdl[o+3] = d[31:24];
        end
    endtask

    task automatic acc(input logic we, input logic [1:0] sz, input logic [31:0] a,
                       input logic [31:0] wd, output logic [31:0] rd, output logic mis,
                       output int lat);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_size = sz; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        lat = 1;
        while (!cpu_done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        rd  = cpu_rdata;
        mis = cpu_misalign;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        mis;
        int          lat;
        int          b0;
        bit          ok;
        for (int i = 0; i < 1024; i++) mdl[i] = 8'h00;

        // R10: reset state
        repeat (3) @(negedge clk);
        chk(!cpu_done && !cpu_misalign && !ext_valid, "R10 in reset", {29'b0, cpu_done, cpu_misalign, ext_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cpu_done && !cpu_misalign && !ext_valid, "R10 after reset", {29'b0, cpu_done, cpu_misalign, ext_valid}, 0);

        // R3 R6: word writes across the whole array via cached-kernel alias
        b0 = bus_cnt;
        for (int w = 0; w < 256; w++) begin
            acc(1'b1, 2'b10, 32'h9F80_0000 | 32'(4*w), pat(w), rd, mis, lat);
            mdl_wr(2'b10, 4*w, pat(w));
            if (w == 0 || w == 255) chk(lat == 1 && !mis, "R6 write hit latency", 32'(lat), 1);
        end
        chk(bus_cnt == b0, "R6 no bus on word writes", 32'(bus_cnt - b0), 0);

        // R3 R5 R6: byte reads at every offset via user segment
        ok = 1;
        for (int o = 0; o < 1024; o++) begin
            acc(1'b0, 2'b00, 32'h1F80_0000 | 32'(o), 32'hFFFF_FFFF, rd, mis, lat);
            if (rd !== mdl_rd(2'b00, o) || lat != 1) begin
                chk(0, "R3 byte read", rd, mdl_rd(2'b00, o));
                ok = 0;
            end
        end
        chk(ok, "R3 R5 byte sweep", 0, 0);
        chk(bus_cnt == b0, "R6 no bus on byte reads", 32'(bus_cnt - b0), 0);

        // R4: byte writes store only low 8 bits; check with word reads (R3)
        for (int o = 0; o < 1024; o += 3) begin
            acc(1'b1, 2'b00, 32'h0F80_0000 | 32'h1000_0000 | 32'(o), pat(o + 7), rd, mis, lat);
            mdl_wr(2'b00, o, pat(o + 7));
        end
        ok = 1;
        for (int w = 0; w < 256; w++) begin
            acc(1'b0, 2'b10, 32'h1F80_0000 | 32'(4*w), 0, rd, mis, lat);
            if (rd !== mdl_rd(2'b10, 4*w)) begin
                chk(0, "R4 word after byte writes", rd, mdl_rd(2'b10, 4*w));
                ok = 0;
            end
        end
        chk(ok, "R4 byte write sweep", 0, 0);

        // R4 R5: halfword writes at offsets 2 mod 4, then halfword reads everywhere
        for (int o = 2; o < 1024; o += 4) begin
            acc(1'b1, 2'b01, 32'h9F80_0000 | 32'(o), pat(o + 11), rd, mis, lat);
            mdl_wr(2'b01, o, pat(o + 11));
        end
        ok = 1;
        for (int o = 0; o < 1024; o += 2) begin
            acc(1'b0, 2'b01, 32'h9F80_0000 | 32'(o), 0, rd, mis, lat);
            if (rd !== mdl_rd(2'b01, o) || mis) begin
                chk(0, "R5 halfword read", rd, mdl_rd(2'b01, o));
                ok = 0;
            end
        end
        chk(ok, "R4 R5 halfword sweep", 0, 0);

        // R1: another user-segment alias of the same physical window hits
        acc(1'b0, 2'b10, 32'h3F80_0010, 0, rd, mis, lat);
        chk(rd === mdl_rd(2'b10, 16) && lat == 1, "R1 alias 0x3F800010 hit", rd, mdl_rd(2'b10, 16));

        // R7: misaligned halfwords and words
        b0 = bus_cnt;
        for (int o = 1; o < 16; o += 2) begin
            acc(1'b1, 2'b01, 32'h1F80_0000 | 32'(o), 32'hFFFF_FFFF, rd, mis, lat);
            chk(mis && lat == 1 && rd == 0, "R7 misaligned half", {31'b0, mis}, 1);
        end
        for (int o = 1; o < 4; o++) begin
            acc(1'b1, 2'b10, 32'h1F80_0020 | 32'(o), 32'hFFFF_FFFF, rd, mis, lat);
            chk(mis && lat == 1, "R7 misaligned word", {31'b0, mis}, 1);
            acc(1'b0, 2'b11, 32'hBF80_0020 | 32'(o), 0, rd, mis, lat);
            chk(mis && rd == 0, "R7 misaligned uncached read", rd, 0);
        end
        chk(bus_cnt == b0, "R7 no bus on misaligned", 32'(bus_cnt - b0), 0);
        ok = 1;
        for (int w = 0; w < 12; w++) begin
            acc(1'b0, 2'b10, 32'h1F80_0000 | 32'(4*w), 0, rd, mis, lat);
            if (rd !== mdl_rd(2'b10, 4*w)) ok = 0;
        end
        chk(ok, "R7 memory unchanged after misaligned writes", 0, 0);

        // R2 R8 R5: bus-routed addresses with varying latency
        for (int l = 0; l < 4; l++) begin
            bus_lat = l;
            begin
                logic [31:0] alist [6];
                logic [1:0]  slist [6];
                alist = '{32'hBF80_0000, 32'hBF80_0123, 32'hDF80_0004, 32'h1F80_0400, 32'h1F7F_FFFC, 32'hFF80_0002};
                slist = '{2'b10, 2'b00, 2'b10, 2'b10, 2'b10, 2'b01};
                for (int k = 0; k < 6; k++) begin
                    b0 = bus_cnt;
                    acc(1'b0, slist[k], alist[k], 0, rd, mis, lat);
                    chk(bus_cnt == b0 + 1 && last_addr == (alist[k] & 32'h1FFF_FFFF),
                        "R2 routed to bus with physical address", last_addr, alist[k] & 32'h1FFF_FFFF);
                    chk(rd === zmask(slist[k], bus_word(alist[k] & 32'h1FFF_FFFF)),
                        "R5 bus read zero-extended", rd, zmask(slist[k], bus_word(alist[k] & 32'h1FFF_FFFF)));
                    chk(lat == 2 + l, "R8 done one cycle after handshake", 32'(lat), 32'(2 + l));
                end
            end
        end

        // R2: uncached write goes to the bus and leaves the scratchpad alone
        bus_lat = 1;
        b0 = bus_cnt;
        acc(1'b1, 2'b10, 32'hBF80_0008, 32'hCAFE_F00D, rd, mis, lat);
        chk(bus_cnt == b0 + 1 && last_we && last_wdata == 32'hCAFE_F00D, "R2 uncached write on bus", last_wdata, 32'hCAFE_F00D);
        acc(1'b0, 2'b10, 32'h9F80_0008, 0, rd, mis, lat);
        chk(rd === mdl_rd(2'b10, 8), "R2 scratchpad untouched by uncached write", rd, mdl_rd(2'b10, 8));

        // R9: request during an outstanding bus access is ignored
        bus_lat = 4;
        b0 = bus_cnt;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_size = 2'b10; cpu_addr = 32'hBF80_0040; cpu_wdata = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_size = 2'b10; cpu_addr = 32'h1F80_0010; cpu_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        cpu_req = 1'b0;
        repeat (10) @(negedge clk);
        chk(bus_cnt == b0 + 1, "R9 single bus access", 32'(bus_cnt - b0), 1);
        acc(1'b0, 2'b10, 32'h1F80_0010, 0, rd, mis, lat);
        chk(rd === mdl_rd(2'b10, 16), "R9 busy request did not write", rd, mdl_rd(2'b10, 16));

        // R3: explicit little-endian lane order check
        acc(1'b1, 2'b10, 32'h1F80_0100, 32'h4433_2211, rd, mis, lat);
        mdl_wr(2'b10, 256, 32'h4433_2211);
        acc(1'b0, 2'b00, 32'h1F80_0100, 0, rd, mis, lat);
        chk(rd == 32'h11, "R3 lowest offset holds bits 7:0", rd, 32'h11);
        acc(1'b0, 2'b01, 32'h1F80_0102, 0, rd, mis, lat);
        chk(rd == 32'h4433, "R3 upper halfword", rd, 32'h4433);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule